// File: doc/BRIEF.md
# Device-Failure Tolerant Memory Codeword Protection

This block protects one memory access of 64 data bytes that is stored across 18 memory devices of 4 bytes each. Sixteen devices hold data and the last two hold check bytes. On the write side it computes the check bytes and forms the physical word. On the read side it repairs any damage that stays inside a single device, up to and including a device that returns nothing but garbage. Patterns it cannot repair are flagged, not silently passed on.

The word is treated as four interleaved Reed-Solomon codes of length 18 over GF(2^8). Each device gives exactly one byte to each interleave. A dead device therefore damages at most one symbol in each interleave. The physical word has a nineteenth, spare device slot. A configuration input can name one device position that lives in the spare slot from then on. Writes copy that position's bytes into the spare slot. Reads take that position's bytes from the spare slot and ignore the original slot.

The syndrome calculation, error location and correction all happen in one combinational pass. A single output register stage follows, so every result appears one cycle after it is accepted. Both the write and read paths use a valid/ready handshake.

Top module: `chipkill_ecc`

## Requirements
- R1: Encode places data bits [32d+31:32d] in physical slot d for d = 0..15. Byte lane l of slot d is bits [32d+8l+7:32d+8l]. Check bytes go in slots 16 and 17, lane by lane. They are chosen so that for each lane l, S0 = XOR of the 18 lane-l bytes = 0 and S1 = XOR of (byte of slot d) times alpha^d = 0. The field is GF(2^8) with x^8+x^4+x^3+x^2+1 and alpha = 0x02.
- R2: A read word whose syndromes are zero in every lane returns its 16 data slots unchanged, with corrected = 0, uncorrectable = 0 and device index = 0. The device index is 0 whenever corrected is 0.
- R3: Any nonzero corruption confined to one data device d (a single bit up to all 32 bits) is repaired. Corrected = 1, uncorrectable = 0 and the device index is d.
- R4: Corruption confined to check device 16 or 17 leaves the data unchanged, with corrected = 1 and the device index set to that device.
- R5: If any lane has exactly one of its two syndromes at zero, the read reports uncorrectable = 1 and corrected = 0. The raw data slots are returned unchanged. An example is the same byte error added to two devices in one lane.
- R6: If the damaged lanes are each repairable on their own but point at different devices, the read reports uncorrectable = 1 and corrected = 0. Corrected and uncorrectable are never both 1.
- R7: With spare steering active for position k (valid = 1, k < 18), slot 18 of the encoded word is a copy of slot k. Without steering, slot 18 is all zero.
- R8: With spare steering active for position k, the read takes position k from slot 18. Any content of slot k is ignored, and damage in another device is still repaired.
- R9: A steering index of 18 or more is treated as steering off on both paths.
- R10: While an output is valid and not taken, it holds its value and the path's ready is low, so no new input is accepted.
- R11: After reset both output valids are 0 and both readies are 1.
- R12: With the output taken every cycle, each path accepts one input per cycle and presents its result on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spare_valid_i | input | 1 | Spare steering enabled |
| spare_idx_i | input | 5 | Device position moved to the spare slot |
| enc_valid_i | input | 1 | Write data offered |
| enc_ready_o | output | 1 | Write data accepted this cycle |
| enc_data_i | input | 512 | Write data, 16 devices of 32 bits |
| enc_out_valid_o | output | 1 | Encoded word available |
| enc_out_ready_i | input | 1 | Encoded word taken |
| enc_word_o | output | 608 | Physical word, 19 slots of 32 bits |
| dec_valid_i | input | 1 | Read word offered |
| dec_ready_o | output | 1 | Read word accepted this cycle |
| dec_word_i | input | 608 | Physical read word, 19 slots of 32 bits |
| dec_out_valid_o | output | 1 | Decode result available |
| dec_out_ready_i | input | 1 | Decode result taken |
| dec_data_o | output | 512 | Corrected data |
| dec_corrected_o | output | 1 | A single-device error was repaired |
| dec_uncorr_o | output | 1 | Damage could not be repaired |
| dec_dev_o | output | 5 | Index of the repaired device |

## Verification
The bench targets the damage patterns where a decoder most easily goes wrong. These are whole-device corruption of data and check devices, a pair of equal byte errors that cancel one syndrome, and two lanes that each look repairable but blame different devices. A decoder that corrected lanes independently would return silently mixed data in the last case and never raise the flag. A decoder that trusted S1 alone would miscorrect the cancelling pair. Spare steering is tested on both paths: the original slot is filled with garbage, and out-of-range indices are used. A wrong steering multiplexer shows up as a spurious repair or a missing copy in slot 18. Back-pressure and back-to-back traffic expose an output stage that drops, overwrites or duplicates results.

// File: rtl/ck_ecc_pkg.sv
package ck_ecc_pkg;

    localparam int SYM_W = 8;
    localparam logic [SYM_W-1:0] GF_POLY_LO = 8'h1D;   // x^8 + x^4 + x^3 + x^2 + 1

    // multiply by alpha (0x02)
    function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? GF_POLY_LO : '0);
    endfunction

    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                 input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] acc;
        logic [SYM_W-1:0] sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic logic [SYM_W-1:0] gf_alpha_pow(input int n);
        logic [SYM_W-1:0] r;
        r = 8'h01;
        for (int i = 0; i < n; i++) r = gf_xtime(r);
        return r;
    endfunction

    // inverse as a^254, used for constants only
    function automatic logic [SYM_W-1:0] gf_inv(input logic [SYM_W-1:0] a);
        logic [SYM_W-1:0] r;
        r = 8'h01;
        for (int i = 0; i < 254; i++) r = gf_mul(r, a);
        return r;
    endfunction

endpackage

// File: rtl/ck_encoder.sv
module ck_encoder
    import ck_ecc_pkg::*;
#(
    parameter int NUM_DEV = 18,
    parameter int LANES   = 4,
    localparam int DEV_W  = LANES * SYM_W,
    localparam int NDATA  = NUM_DEV - 2,
    localparam int DATA_W = NDATA * DEV_W,
    localparam int CW_W   = NUM_DEV * DEV_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    localparam logic [SYM_W-1:0] W_LO  = gf_alpha_pow(NUM_DEV - 2);
    localparam logic [SYM_W-1:0] W_HI  = gf_alpha_pow(NUM_DEV - 1);
    localparam logic [SYM_W-1:0] K_INV = gf_inv(W_LO ^ W_HI);

    logic [SYM_W-1:0] wprod  [LANES][NDATA];
    logic [SYM_W-1:0] chk_lo [LANES];
    logic [SYM_W-1:0] chk_hi [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar d = 0; d < NDATA; d++) begin : g_dev
            localparam logic [SYM_W-1:0] WD = gf_alpha_pow(d);
            assign wprod[l][d] = gf_mul(data_i[d*DEV_W + l*SYM_W +: SYM_W], WD);
        end

        // Solve p_lo + p_hi = A and p_lo*W_LO + p_hi*W_HI = B
        always_comb begin
            logic [SYM_W-1:0] sum_a;
            logic [SYM_W-1:0] sum_b;
            sum_a = '0;
            sum_b = '0;
            for (int d = 0; d < NDATA; d++) begin
                sum_a = sum_a ^ data_i[d*DEV_W + l*SYM_W +: SYM_W];
                sum_b = sum_b ^ wprod[l][d];
            end
            chk_hi[l] = gf_mul(sum_b ^ gf_mul(sum_a, W_LO), K_INV);
            chk_lo[l] = sum_a ^ chk_hi[l];
        end
    end

    always_comb begin
        cw_o = '0;
        cw_o[DATA_W-1:0] = data_i;
        for (int l = 0; l < LANES; l++) begin
            cw_o[(NUM_DEV-2)*DEV_W + l*SYM_W +: SYM_W] = chk_lo[l];
            cw_o[(NUM_DEV-1)*DEV_W + l*SYM_W +: SYM_W] = chk_hi[l];
        end
    end

endmodule

// File: rtl/ck_syndrome_lane.sv
module ck_syndrome_lane
    import ck_ecc_pkg::*;
#(
    parameter int NUM_DEV = 18,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_DEV*SYM_W-1:0] syms_i,
    output logic [SYM_W-1:0]         s0_o,
    output logic                     err_o,
    output logic                     fixable_o,
    output logic [IDX_W-1:0]         loc_o
);

    logic [SYM_W-1:0]   wsym [NUM_DEV];
    logic [NUM_DEV-1:0] hit;
    logic [SYM_W-1:0]   s1;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_pos
        localparam logic [SYM_W-1:0] WD = gf_alpha_pow(d);
        assign wsym[d] = gf_mul(syms_i[d*SYM_W +: SYM_W], WD);
        // single error at d gives S1 = S0 * alpha^d
        assign hit[d]  = (gf_mul(s0_o, WD) == s1);
    end

    always_comb begin
        s0_o = '0;
        s1   = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            s0_o = s0_o ^ syms_i[d*SYM_W +: SYM_W];
            s1   = s1 ^ wsym[d];
        end
    end

    always_comb begin
        err_o     = (s0_o != '0) || (s1 != '0);
        fixable_o = (s0_o != '0) && (s1 != '0) && (hit != '0);
        loc_o     = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (hit[d]) loc_o = IDX_W'(d);
        end
    end

endmodule

// File: rtl/ck_decoder.sv
module ck_decoder
    import ck_ecc_pkg::*;
#(
    parameter int NUM_DEV = 18,
    parameter int LANES   = 4,
    parameter int IDX_W   = 5,
    localparam int DEV_W  = LANES * SYM_W,
    localparam int NDATA  = NUM_DEV - 2,
    localparam int DATA_W = NDATA * DEV_W,
    localparam int CW_W   = NUM_DEV * DEV_W
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corrected_o,
    output logic              uncorr_o,
    output logic [IDX_W-1:0]  dev_o
);

    logic [NUM_DEV*SYM_W-1:0] lane_syms [LANES];
    logic [SYM_W-1:0]         lane_s0   [LANES];
    logic [LANES-1:0]         lane_err;
    logic [LANES-1:0]         lane_fix;
    logic [IDX_W-1:0]         lane_loc  [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            for (int d = 0; d < NUM_DEV; d++) begin
                lane_syms[l][d*SYM_W +: SYM_W] = cw_i[d*DEV_W + l*SYM_W +: SYM_W];
            end
        end

        ck_syndrome_lane #(
            .NUM_DEV (NUM_DEV),
            .IDX_W   (IDX_W)
        ) u_lane (
            .syms_i    (lane_syms[l]),
            .s0_o      (lane_s0[l]),
            .err_o     (lane_err[l]),
            .fixable_o (lane_fix[l]),
            .loc_o     (lane_loc[l])
        );
    end

    always_comb begin
        logic             any_err;
        logic             bad;
        logic             have_loc;
        logic [IDX_W-1:0] loc;
        any_err  = 1'b0;
        bad      = 1'b0;
        have_loc = 1'b0;
        loc      = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_err[l]) begin
                any_err = 1'b1;
                if (!lane_fix[l]) begin
                    bad = 1'b1;
                end else if (have_loc && (lane_loc[l] != loc)) begin
                    bad = 1'b1;
                end else begin
                    have_loc = 1'b1;
                    loc      = lane_loc[l];
                end
            end
        end

        corrected_o = any_err && !bad;
        uncorr_o    = bad;
        dev_o       = corrected_o ? loc : '0;

        data_o = cw_i[DATA_W-1:0];
        if (corrected_o && (loc < IDX_W'(NDATA))) begin
            for (int l = 0; l < LANES; l++) begin
                data_o[int'(loc)*DEV_W + l*SYM_W +: SYM_W] =
                    data_o[int'(loc)*DEV_W + l*SYM_W +: SYM_W] ^ lane_s0[l];
            end
        end
    end

endmodule

// File: rtl/chipkill_ecc.sv
module chipkill_ecc
    import ck_ecc_pkg::*;
#(
    parameter int NUM_DEV = 18,
    parameter int LANES   = 4,
    localparam int DEV_W  = LANES * SYM_W,
    localparam int NDATA  = NUM_DEV - 2,
    localparam int DATA_W = NDATA * DEV_W,
    localparam int CW_W   = NUM_DEV * DEV_W,
    localparam int PHYS_W = (NUM_DEV + 1) * DEV_W,
    localparam int IDX_W  = $clog2(NUM_DEV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spare_valid_i,
    input  logic [IDX_W-1:0]  spare_idx_i,
    input  logic              enc_valid_i,
    output logic              enc_ready_o,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_out_valid_o,
    input  logic              enc_out_ready_i,
    output logic [PHYS_W-1:0] enc_word_o,
    input  logic              dec_valid_i,
    output logic              dec_ready_o,
    input  logic [PHYS_W-1:0] dec_word_i,
    output logic              dec_out_valid_o,
    input  logic              dec_out_ready_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_corrected_o,
    output logic              dec_uncorr_o,
    output logic [IDX_W-1:0]  dec_dev_o
);

    typedef struct packed {
        logic              enc_vld;
        logic [PHYS_W-1:0] enc_word;
        logic              dec_vld;
        logic [DATA_W-1:0] dec_data;
        logic              dec_corr;
        logic              dec_unc;
        logic [IDX_W-1:0]  dec_dev;
    } stage_t;

    stage_t st_d, st_q;

    logic              spare_on;
    logic [CW_W-1:0]   enc_cw;
    logic [PHYS_W-1:0] enc_phys;
    logic [CW_W-1:0]   rd_cw;
    logic [DATA_W-1:0] rd_data;
    logic              rd_corr;
    logic              rd_unc;
    logic [IDX_W-1:0]  rd_dev;

    assign spare_on = spare_valid_i && (spare_idx_i < IDX_W'(NUM_DEV));

    ck_encoder #(
        .NUM_DEV (NUM_DEV),
        .LANES   (LANES)
    ) u_enc (
        .data_i (enc_data_i),
        .cw_o   (enc_cw)
    );

    // write: duplicate the steered position into the spare slot
    always_comb begin
        enc_phys = '0;
        enc_phys[CW_W-1:0] = enc_cw;
        if (spare_on) begin
            enc_phys[CW_W +: DEV_W] = enc_cw[int'(spare_idx_i)*DEV_W +: DEV_W];
        end
    end

    // read: the steered position comes from the spare slot
    always_comb begin
        for (int d = 0; d < NUM_DEV; d++) begin
            if (spare_on && (spare_idx_i == IDX_W'(d))) begin
                rd_cw[d*DEV_W +: DEV_W] = dec_word_i[CW_W +: DEV_W];
            end else begin
                rd_cw[d*DEV_W +: DEV_W] = dec_word_i[d*DEV_W +: DEV_W];
            end
        end
    end

    ck_decoder #(
        .NUM_DEV (NUM_DEV),
        .LANES   (LANES),
        .IDX_W   (IDX_W)
    ) u_dec (
        .cw_i        (rd_cw),
        .data_o      (rd_data),
        .corrected_o (rd_corr),
        .uncorr_o    (rd_unc),
        .dev_o       (rd_dev)
    );

    assign enc_ready_o = !st_q.enc_vld || enc_out_ready_i;
    assign dec_ready_o = !st_q.dec_vld || dec_out_ready_i;

    always_comb begin
        st_d = st_q;
        if (enc_out_ready_i) st_d.enc_vld = 1'b0;
        if (enc_valid_i && enc_ready_o) begin
            st_d.enc_vld  = 1'b1;
            st_d.enc_word = enc_phys;
        end
        if (dec_out_ready_i) st_d.dec_vld = 1'b0;
        if (dec_valid_i && dec_ready_o) begin
            st_d.dec_vld  = 1'b1;
            st_d.dec_data = rd_data;
            st_d.dec_corr = rd_corr;
            st_d.dec_unc  = rd_unc;
            st_d.dec_dev  = rd_dev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_out_valid_o = st_q.enc_vld;
    assign enc_word_o      = st_q.enc_word;
    assign dec_out_valid_o = st_q.dec_vld;
    assign dec_data_o      = st_q.dec_data;
    assign dec_corrected_o = st_q.dec_corr;
    assign dec_uncorr_o    = st_q.dec_unc;
    assign dec_dev_o       = st_q.dec_dev;

endmodule

// File: rtl/chipkill_ecc_chk.sv
module chipkill_ecc_chk
    import ck_ecc_pkg::*;
#(
    parameter int NUM_DEV = 18,
    parameter int LANES   = 4,
    localparam int DEV_W  = LANES * SYM_W,
    localparam int DATA_W = (NUM_DEV - 2) * DEV_W,
    localparam int PHYS_W = (NUM_DEV + 1) * DEV_W,
    localparam int IDX_W  = $clog2(NUM_DEV + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid_i,
    input logic              enc_ready_o,
    input logic              enc_out_valid_o,
    input logic              enc_out_ready_i,
    input logic [PHYS_W-1:0] enc_word_o,
    input logic              dec_valid_i,
    input logic              dec_ready_o,
    input logic              dec_out_valid_o,
    input logic              dec_out_ready_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_corrected_o,
    input logic              dec_uncorr_o,
    input logic [IDX_W-1:0]  dec_dev_o
);

    p_enc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid_o && !enc_out_ready_i |=> enc_out_valid_o && $stable(enc_word_o));

    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid_o && !dec_out_ready_i |=> dec_out_valid_o && $stable(dec_data_o)
            && $stable(dec_corrected_o) && $stable(dec_uncorr_o) && $stable(dec_dev_o));

    p_enc_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_i && enc_ready_o |=> enc_out_valid_o);

    p_dec_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i && dec_ready_o |=> dec_out_valid_o);

    p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid_o |-> !(dec_corrected_o && dec_uncorr_o));

    p_dev_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid_o && dec_corrected_o |-> dec_dev_o < IDX_W'(NUM_DEV));

    p_dev_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid_o && !dec_corrected_o |-> dec_dev_o == '0);

endmodule

bind chipkill_ecc chipkill_ecc_chk #(
    .NUM_DEV (NUM_DEV),
    .LANES   (LANES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .enc_valid_i     (enc_valid_i),
    .enc_ready_o     (enc_ready_o),
    .enc_out_valid_o (enc_out_valid_o),
    .enc_out_ready_i (enc_out_ready_i),
    .enc_word_o      (enc_word_o),
    .dec_valid_i     (dec_valid_i),
    .dec_ready_o     (dec_ready_o),
    .dec_out_valid_o (dec_out_valid_o),
    .dec_out_ready_i (dec_out_ready_i),
    .dec_data_o      (dec_data_o),
    .dec_corrected_o (dec_corrected_o),
    .dec_uncorr_o    (dec_uncorr_o),
    .dec_dev_o       (dec_dev_o)
);

// File: tb/chipkill_ecc_tb.sv
`timescale 1ns/1ps
module chipkill_ecc_tb;

    localparam int DW = 512;
    localparam int PW = 608;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          spare_valid;
    logic [4:0]    spare_idx;
    logic          enc_valid;
    logic          enc_ready;
    logic [DW-1:0] enc_data;
    logic          enc_out_valid;
    logic          enc_out_ready;
    logic [PW-1:0] enc_word;
    logic          dec_valid;
    logic          dec_ready;
    logic [PW-1:0] dec_word;
    logic          dec_out_valid;
    logic          dec_out_ready;
    logic [DW-1:0] dec_data;
    logic          dec_corr;
    logic          dec_unc;
    logic [4:0]    dec_dev;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    chipkill_ecc u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .spare_valid_i   (spare_valid),
        .spare_idx_i     (spare_idx),
        .enc_valid_i     (enc_valid),
        .enc_ready_o     (enc_ready),
        .enc_data_i      (enc_data),
        .enc_out_valid_o (enc_out_valid),
        .enc_out_ready_i (enc_out_ready),
        .enc_word_o      (enc_word),
        .dec_valid_i     (dec_valid),
        .dec_ready_o     (dec_ready),
        .dec_word_i      (dec_word),
        .dec_out_valid_o (dec_out_valid),
        .dec_out_ready_i (dec_out_ready),
        .dec_data_o      (dec_data),
        .dec_corrected_o (dec_corr),
        .dec_uncorr_o    (dec_unc),
        .dec_dev_o       (dec_dev)
    );

    // ---------------- reference arithmetic ----------------
    function automatic logic [7:0] tb_xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1D : 8'h00);
    endfunction

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        logic [7:0] s;
        r = 0;
        s = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= s;
            s = tb_xt(s);
        end
        return r;
    endfunction

    function automatic logic [7:0] tb_apow(input int n);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 0; i < n; i++) r = tb_xt(r);
        return r;
    endfunction

    // expected physical word, check bytes found by exhaustive search
    function automatic logic [PW-1:0] tb_build(input logic [DW-1:0] d, input logic sv,
                                               input logic [4:0] si);
        logic [PW-1:0] w;
        logic [7:0]    a;
        logic [7:0]    b;
        logic [7:0]    lo;
        logic [7:0]    hi;
        w = '0;
        w[DW-1:0] = d;
        for (int l = 0; l < 4; l++) begin
            a = 0;
            b = 0;
            for (int k = 0; k < 16; k++) begin
                a ^= d[k*32 + l*8 +: 8];
                b ^= tb_mul(d[k*32 + l*8 +: 8], tb_apow(k));
            end
            lo = 0;
            hi = 0;
            for (int p = 0; p < 256; p++) begin
                if ((tb_mul(a ^ 8'(p), tb_apow(16)) ^ tb_mul(8'(p), tb_apow(17))) == b) begin
                    hi = 8'(p);
                    lo = a ^ 8'(p);
                end
            end
            w[16*32 + l*8 +: 8] = lo;
            w[17*32 + l*8 +: 8] = hi;
        end
        if (sv && si < 18) w[18*32 +: 32] = w[int'(si)*32 +: 32];
        return w;
    endfunction

    function automatic logic [DW-1:0] rnd512();
        logic [DW-1:0] r;
        for (int j = 0; j < 16; j++) r[j*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- transactions ----------------
    task automatic enc_xact(input logic [DW-1:0] d, output logic [PW-1:0] w, output logic v);
        @(negedge clk);
        enc_valid = 1'b1;
        enc_data  = d;
        @(negedge clk);
        enc_valid = 1'b0;
        v = enc_out_valid;
        w = enc_word;
    endtask

    task automatic dec_xact(input logic [PW-1:0] w, output logic [DW-1:0] d,
                            output logic c, output logic u, output logic [4:0] dv,
                            output logic v);
        @(negedge clk);
        dec_valid = 1'b1;
        dec_word  = w;
        @(negedge clk);
        dec_valid = 1'b0;
        v  = dec_out_valid;
        d  = dec_data;
        c  = dec_corr;
        u  = dec_unc;
        dv = dec_dev;
    endtask

    task automatic expect_dec(input string req, input logic [PW-1:0] w,
                              input logic [DW-1:0] ed, input logic ec, input logic eu,
                              input logic [4:0] edev);
        logic [DW-1:0] d;
        logic c, u, v;
        logic [4:0] dv;
        dec_xact(w, d, c, u, dv, v);
        chk(req, "dec valid", PW'(v), PW'(1));
        chk(req, "dec data", PW'(d), PW'(ed));
        chk(req, "corrected", PW'(c), PW'(ec));
        chk(req, "uncorrectable", PW'(u), PW'(eu));
        chk(req, "device", PW'(dv), PW'(edev));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R11", "enc_out_valid", PW'(enc_out_valid), PW'(0));
        chk("R11", "dec_out_valid", PW'(dec_out_valid), PW'(0));
        chk("R11", "enc_ready", PW'(enc_ready), PW'(1));
        chk("R11", "dec_ready", PW'(dec_ready), PW'(1));
    endtask

    task automatic t_encode();
        logic [PW-1:0] w;
        logic v;
        logic [DW-1:0] pats [3];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = rnd512();
        for (int k = 0; k < 3; k++) begin
            enc_xact(pats[k], w, v);
            chk("R1", "enc valid", PW'(v), PW'(1));
            chk("R1", "enc word", w, tb_build(pats[k], 1'b0, 5'd0));
        end
    endtask

    task automatic t_clean();
        logic [DW-1:0] d;
        d = rnd512();
        expect_dec("R2", tb_build(d, 0, 0), d, 0, 0, 0);
        d = '1;
        expect_dec("R2", tb_build(d, 0, 0), d, 0, 0, 0);
    endtask

    task automatic t_single();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        int devs [4] = '{0, 5, 15, 9};
        for (int k = 0; k < 4; k++) begin
            d = rnd512();
            w = tb_build(d, 0, 0);
            if (k == 3) w[devs[k]*32 + 13] = ~w[devs[k]*32 + 13];      // one bit
            else if (k == 1) w[devs[k]*32 +: 32] = ~w[devs[k]*32 +: 32]; // whole device
            else w[devs[k]*32 +: 32] ^= 32'hA5C3_0F71;
            expect_dec("R3", w, d, 1, 0, 5'(devs[k]));
        end
    endtask

    task automatic t_check_dev();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        d = rnd512();
        w = tb_build(d, 0, 0);
        w[16*32 +: 32] ^= 32'hFFFF_FFFF;
        expect_dec("R4", w, d, 1, 0, 5'd16);
        w = tb_build(d, 0, 0);
        w[17*32 +: 32] ^= 32'h0000_8001;
        expect_dec("R4", w, d, 1, 0, 5'd17);
    endtask

    task automatic t_cancel();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        d = rnd512();
        w = tb_build(d, 0, 0);
        w[2*32 + 8 +: 8] ^= 8'h5A;   // lane 1, device 2
        w[7*32 + 8 +: 8] ^= 8'h5A;   // lane 1, device 7: S0 cancels
        expect_dec("R5", w, w[DW-1:0], 0, 1, 0);
    endtask

    task automatic t_disagree();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        d = rnd512();
        w = tb_build(d, 0, 0);
        w[3*32 + 0 +: 8]  ^= 8'h11;  // lane 0 blames device 3
        w[12*32 + 16 +: 8] ^= 8'h22; // lane 2 blames device 12
        expect_dec("R6", w, w[DW-1:0], 0, 1, 0);
    endtask

    task automatic t_spare_write();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        logic v;
        d = rnd512();
        spare_valid = 1'b1; spare_idx = 5'd4;
        enc_xact(d, w, v);
        chk("R7", "spare copy of slot 4", w, tb_build(d, 1, 5'd4));
        spare_idx = 5'd17;
        enc_xact(d, w, v);
        chk("R7", "spare copy of slot 17", w, tb_build(d, 1, 5'd17));
        spare_idx = 5'd20;
        enc_xact(d, w, v);
        chk("R9", "index 20 gives empty spare", w, tb_build(d, 0, 5'd0));
        spare_valid = 1'b0; spare_idx = 5'd4;
        enc_xact(d, w, v);
        chk("R7", "steering off gives empty spare", PW'(w[18*32 +: 32]), PW'(0));
    endtask

    task automatic t_spare_read();
        logic [DW-1:0] d;
        logic [PW-1:0] w;
        d = rnd512();
        spare_valid = 1'b1; spare_idx = 5'd6;
        w = tb_build(d, 1, 5'd6);
        w[6*32 +: 32] = ~w[6*32 +: 32];
        expect_dec("R8", w, d, 0, 0, 0);
        w[10*32 +: 32] ^= 32'h0F0F_1234;
        expect_dec("R8", w, d, 1, 0, 5'd10);
        spare_idx = 5'd25;
        w = tb_build(d, 1, 5'd6);
        w[6*32 +: 32] ^= 32'h8000_0001;
        expect_dec("R9", w, d, 1, 0, 5'd6);
        spare_valid = 1'b0;
        spare_idx   = 5'd0;
    endtask

    task automatic t_backpressure();
        logic [DW-1:0] d1;
        logic [DW-1:0] d2;
        d1 = rnd512();
        d2 = rnd512();
        @(negedge clk);
        enc_out_ready = 1'b0;
        enc_valid = 1'b1;
        enc_data  = d1;
        @(negedge clk);
        chk("R10", "first held valid", PW'(enc_out_valid), PW'(1));
        chk("R10", "ready low while full", PW'(enc_ready), PW'(0));
        enc_data = d2;
        @(negedge clk);
        chk("R10", "word stable under stall", enc_word, tb_build(d1, 0, 0));
        enc_out_ready = 1'b1;
        @(negedge clk);
        enc_valid = 1'b0;
        chk("R10", "second after drain valid", PW'(enc_out_valid), PW'(1));
        chk("R10", "second after drain word", enc_word, tb_build(d2, 0, 0));
        @(negedge clk);
        chk("R10", "empty after drain", PW'(enc_out_valid), PW'(0));
    endtask

    task automatic t_stream();
        logic [DW-1:0] d [3];
        logic [PW-1:0] w [3];
        for (int k = 0; k < 3; k++) begin
            d[k] = rnd512();
            w[k] = tb_build(d[k], 0, 0);
        end
        w[1][8*32 + 3] = ~w[1][8*32 + 3];
        @(negedge clk);
        dec_valid = 1'b1;
        dec_word  = w[0];
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R12", "stream valid", PW'(dec_out_valid), PW'(1));
            chk("R12", "stream data", PW'(dec_data), PW'(d[k-1]));
            chk("R12", "stream corrected", PW'(dec_corr), PW'(k == 2));
            if (k < 3) dec_word = w[k];
            else dec_valid = 1'b0;
        end
        @(negedge clk);
        chk("R12", "stream drained", PW'(dec_out_valid), PW'(0));
    endtask

    // ---------------- run ----------------
    initial begin
        rst_n = 1'b0;
        spare_valid = 1'b0; spare_idx = '0;
        enc_valid = 1'b0; enc_data = '0; enc_out_ready = 1'b1;
        dec_valid = 1'b0; dec_word = '0; dec_out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_check_dev();
        t_cancel();
        t_disagree();
        t_spare_write();
        t_spare_read();
        t_backpressure();
        t_stream();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule